// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration bitstream into a target FPGA over that device's slave-serial port. A command starts a full load. The sequencer drives the target's active-low program pin for a fixed pulse, then checks that the target's DONE signal has gone low. It waits out the programming latency, then shifts the incoming byte stream out on a serial clock/data pair. After the last byte it keeps clocking all-ones filler bytes until DONE rises, and it finishes with one more filler byte.

The byte stream arrives on a valid/ready handshake with a last marker. The outcome is held on a result code until the next command. Requests for partial reconfiguration are refused without touching the target. If DONE fails to rise within a bounded number of filler bytes, the load ends with a timeout code. DONE is synchronised before use. A status output tells whether the target is currently held in its unconfigured (reset) state.

Top module: `fpga_serial_loader`

## Requirements
- R1: After reset and whenever `busy` is low, `prog_n` is high, `cclk` is low and `sdata` is high.
- R2: An accepted start (with `partial` low while idle) drives `prog_n` low for exactly `PROG_CYCLES` clock cycles.
- R3: If synchronised DONE is high in the cycle after the program pulse ends, the load stops with `result` = 3 (unexpected DONE), and no serial clock edge is issued.
- R4: No rising edge of `cclk` occurs within `LATENCY_CYCLES` clock cycles after `prog_n` returns high.
- R5: A start with `partial` high while idle sets `result` = 2 (unsupported) in the next cycle. It leaves `busy` low and `prog_n` high.
- R6: Each byte goes out MSB first as 8 `cclk` periods. `sdata` changes only together with a falling `cclk` and is stable while `cclk` is high. Each half period lasts `CLK_DIV` clock cycles.
- R7: `in_ready` is high only in the data phase while the serialiser is empty. A byte accepted with `in_last` high ends the data phase, and no further stream bytes are taken.
- R8: If DONE is already high when the last data byte has been shifted, exactly one 0xFF byte follows, and `result` becomes 1 (success).
- R9: While DONE is low after the data, 0xFF bytes are sent and DONE is sampled after each one. Once DONE is seen high, exactly one more 0xFF byte is sent and `result` becomes 1.
- R10: If DONE is still low after `MAX_FILL` filler bytes, the load stops with `result` = 4 (timeout) and no further filler.
- R11: `target_in_reset` is high when the two-flop-synchronised `cfg_done` is low, and low otherwise.
- R12: `result` holds its value while idle until the next start. An accepted start clears it to 0 (none) in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load command, taken only while idle |
| partial | input | 1 | Partial-reconfiguration request flag sampled with `start` |
| in_data | input | 8 | Bitstream byte |
| in_valid | input | 1 | `in_data` is valid |
| in_last | input | 1 | Current byte is the final one of the stream |
| in_ready | output | 1 | Sequencer takes the byte this cycle |
| cfg_done | input | 1 | Target DONE signal, asynchronous |
| prog_n | output | 1 | Target program pin, active low |
| cclk | output | 1 | Serial configuration clock |
| sdata | output | 1 | Serial configuration data |
| busy | output | 1 | A load is in progress |
| result | output | 3 | 0 none, 1 success, 2 unsupported, 3 unexpected DONE, 4 timeout |
| target_in_reset | output | 1 | Target reports unconfigured (DONE low) |

## Verification
The properties assume that `start` is only meaningful while `busy` is low. They also assume that a stream byte, once offered, is held with its `in_last` flag until `in_ready` takes it. The stimulus pulses `start` for one cycle only between loads. It changes the stream inputs on the falling clock edge and keeps them steady until a handshake is seen. It moves `cfg_done` only at points tied to the serial traffic it observes: before the pulse for the abort case, or at the first bit of a chosen byte for the filler cases. It never drops `cfg_done` during a load.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  typedef enum logic [2:0] {
    RES_NONE        = 3'd0,
    RES_OK          = 3'd1,
    RES_UNSUPPORTED = 3'd2,
    RES_DONE_EARLY  = 3'd3,
    RES_TIMEOUT     = 3'd4
  } result_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PROG,
    SQ_CHECK,
    SQ_LAT,
    SQ_DATA,
    SQ_TAIL,
    SQ_FINAL
  } seq_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // bits needed to hold a count from 0 up to n
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/fsl_shifter.sv
module fsl_shifter
  import fsl_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  output logic       busy,
  output logic       sclk,
  output logic       sdata
);
  localparam int DCW = cnt_bits(CLK_DIV);

  logic [7:0]     sh;
  logic [2:0]     bit_idx;
  logic [DCW-1:0] div_cnt;
  wire half_end = (div_cnt == DCW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      sdata   <= 1'b1;
      sh      <= '0;
      bit_idx <= '0;
      div_cnt <= '0;
    end else if (!busy) begin
      if (load) begin
        busy    <= 1'b1;
        sh      <= load_byte;
        sdata   <= load_byte[7];
        bit_idx <= '0;
        div_cnt <= '0;
      end
    end else if (!half_end) begin
      div_cnt <= div_cnt + 1'b1;
    end else begin
      div_cnt <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        if (bit_idx == 3'd7) begin
          busy  <= 1'b0;
          sdata <= 1'b1;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          sh      <= {sh[6:0], 1'b1};
          sdata   <= sh[6];
        end
      end
    end
  end
endmodule

// File: rtl/fpga_serial_loader.sv
module fpga_serial_loader
  import fsl_pkg::*;
#(
  parameter int PROG_CYCLES    = 100,
  parameter int LATENCY_CYCLES = 750000,
  parameter int CLK_DIV        = 4,
  parameter int MAX_FILL       = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       partial,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       cfg_done,
  output logic       prog_n,
  output logic       cclk,
  output logic       sdata,
  output logic       busy,
  output logic [2:0] result,
  output logic       target_in_reset
);
  localparam int WCW = cnt_bits(max_of(PROG_CYCLES, LATENCY_CYCLES));
  localparam int FCW = cnt_bits(MAX_FILL);

  seq_e           state;
  result_e        res_q;
  logic           prog_q;
  logic [WCW-1:0] wait_cnt;
  logic [FCW-1:0] fill_cnt;
  logic           done_s;
  logic           sh_busy;
  logic           sh_load;
  logic [7:0]     sh_byte;

  // named events
  wire prog_release   = (state == SQ_PROG) && (wait_cnt == WCW'(PROG_CYCLES - 1));
  wire lat_end        = (state == SQ_LAT)  && (wait_cnt == WCW'(LATENCY_CYCLES - 1));
  wire byte_accept    = in_ready && in_valid;
  wire tail_idle      = (state == SQ_TAIL) && !sh_busy;
  wire fill_exhausted = (fill_cnt == FCW'(MAX_FILL));
  wire filler_load    = tail_idle && (done_s || !fill_exhausted);

  assign in_ready = (state == SQ_DATA) && !sh_busy;
  assign sh_load  = byte_accept || filler_load;
  assign sh_byte  = byte_accept ? in_data : FILL_BYTE;

  fsl_sync #(.STAGES(2)) u_done_sync (
    .clk(clk), .rst_n(rst_n), .d(cfg_done), .q(done_s)
  );

  fsl_shifter #(.CLK_DIV(CLK_DIV)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_byte(sh_byte),
    .busy(sh_busy), .sclk(cclk), .sdata(sdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      res_q    <= RES_NONE;
      prog_q   <= 1'b1;
      wait_cnt <= '0;
      fill_cnt <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          if (partial) begin
            res_q <= RES_UNSUPPORTED;
          end else begin
            res_q    <= RES_NONE;
            prog_q   <= 1'b0;
            wait_cnt <= '0;
            fill_cnt <= '0;
            state    <= SQ_PROG;
          end
        end
        SQ_PROG: if (prog_release) begin
          prog_q <= 1'b1;
          state  <= SQ_CHECK;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
        SQ_CHECK: if (done_s) begin
          res_q <= RES_DONE_EARLY;
          state <= SQ_IDLE;
        end else begin
          wait_cnt <= '0;
          state    <= SQ_LAT;
        end
        SQ_LAT: if (lat_end) state <= SQ_DATA;
                else         wait_cnt <= wait_cnt + 1'b1;
        SQ_DATA: if (byte_accept && in_last) state <= SQ_TAIL;
        SQ_TAIL: if (!sh_busy) begin
          if (done_s) begin
            state <= SQ_FINAL;
          end else if (fill_exhausted) begin
            res_q <= RES_TIMEOUT;
            state <= SQ_IDLE;
          end else begin
            fill_cnt <= fill_cnt + 1'b1;
          end
        end
        SQ_FINAL: if (!sh_busy) begin
          res_q <= RES_OK;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign prog_n          = prog_q;
  assign busy            = (state != SQ_IDLE);
  assign result          = res_q;
  assign target_in_reset = !done_s;
endmodule

// File: rtl/fsl_checker.sv
module fsl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       partial,
  input logic       busy,
  input logic       prog_n,
  input logic       cclk,
  input logic       sdata,
  input logic       in_ready,
  input logic       sh_busy,
  input logic [2:0] result
);
  // R1
  idle_prog_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (prog_n && !cclk));

  // R5
  partial_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && partial && !busy) |=> (!busy && prog_n && result == 3'd2));

  // R4
  no_clk_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> !cclk);

  // R6
  data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(sdata));

  // R7
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !sh_busy));

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

bind fpga_serial_loader fsl_checker u_fsl_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .partial(partial), .busy(busy),
  .prog_n(prog_n), .cclk(cclk), .sdata(sdata), .in_ready(in_ready),
  .sh_busy(sh_busy), .result(result)
);

// File: tb/test_fpga_serial_loader.sv
module test_fpga_serial_loader;
  localparam int P = 8;
  localparam int L = 40;
  localparam int D = 2;
  localparam int M = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       start = 1'b0, partial = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic       in_ready, prog_n, cclk, sdata, busy, target_in_reset;
  logic [2:0] result;
  logic       force_done = 1'b0;
  int         raise_at = -1;
  int         byte_starts = 0;
  logic       cfg_done;

  int checks = 0, fails = 0;

  assign cfg_done = force_done || (raise_at >= 0 && byte_starts > raise_at);

  fpga_serial_loader #(.PROG_CYCLES(P), .LATENCY_CYCLES(L), .CLK_DIV(D), .MAX_FILL(M))
  i_fpga_serial_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .partial(partial),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .cfg_done(cfg_done), .prog_n(prog_n), .cclk(cclk), .sdata(sdata),
    .busy(busy), .result(result), .target_in_reset(target_in_reset)
  );

  // serial receiver model: MSB first, sampled on rising cclk
  logic [7:0] rx_q[$];
  int         bit_n = 0;
  logic [7:0] rx_sr = '0;
  always @(posedge cclk) begin
    if (bit_n == 0) byte_starts = byte_starts + 1;
    rx_sr = {rx_sr[6:0], sdata};
    bit_n = bit_n + 1;
    if (bit_n == 8) begin
      rx_q.push_back(rx_sr);
      bit_n = 0;
    end
  end

  function automatic int exp_fillers(input bit tmo, input int k);
    return tmo ? M : k + 1;
  endfunction

  function automatic int exp_result(input bit tmo);
    return tmo ? 4 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input bit part);
    @(negedge clk);
    start = 1'b1; partial = part;
    @(negedge clk);
    start = 1'b0; partial = 1'b0;
  endtask

  // one full load of n bytes; DONE rises during filler k (k=0: during last data byte)
  task automatic run_load(input int n, input int k, input bit tmo);
    logic [7:0] data[];
    int base, pw, gap, nf;
    data = new[n];
    foreach (data[i]) data[i] = 8'($urandom);
    base = rx_q.size();
    force_done = 1'b0;
    raise_at = tmo ? -1 : (byte_starts + n - 1 + k);
    pulse_start(1'b0);
    chk(result == 3'd0, "R12 start clears result", int'(result), 0);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          repeat ($urandom_range(0, 3)) @(negedge clk);
          in_valid = 1'b1; in_data = data[i]; in_last = (i == n - 1);
          while (!in_ready) @(negedge clk);
          @(negedge clk);
          in_valid = 1'b0; in_last = 1'b0;
        end
      end
      begin
        pw = 0;
        while (!prog_n) begin pw++; @(negedge clk); end
        chk(pw == P, "R2 program pulse width", pw, P);
        gap = 0;
        while (!cclk) begin gap++; @(negedge clk); end
        chk(gap >= L, "R4 latency before first cclk", gap, L);
      end
    join
    while (busy) @(negedge clk);
    chk(in_ready == 1'b0, "R7 ready low after load", int'(in_ready), 0);
    chk(result == 3'(exp_result(tmo)), tmo ? "R10 timeout code" : "R9 success code",
        int'(result), exp_result(tmo));
    nf = exp_fillers(tmo, k);
    chk(rx_q.size() == base + n + nf, tmo ? "R10 byte count" : (k == 0 ? "R8 byte count" : "R9 byte count"),
        rx_q.size() - base, n + nf);
    for (int i = 0; i < n && base + i < rx_q.size(); i++)
      chk(rx_q[base + i] == data[i], "R6 data byte MSB first", int'(rx_q[base + i]), int'(data[i]));
    for (int i = n; i < n + nf && base + i < rx_q.size(); i++)
      chk(rx_q[base + i] == 8'hFF, "R8 filler value", int'(rx_q[base + i]), 255);
    repeat (5) @(negedge clk);
    chk(result == 3'(exp_result(tmo)), "R12 result held", int'(result), exp_result(tmo));
    chk(prog_n && !cclk && sdata, "R1 idle outputs", int'({prog_n, cclk, sdata}), 5);
    raise_at = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prog_n && !cclk && sdata && !busy, "R1 reset state", int'({prog_n, cclk, sdata, busy}), 10);
    chk(result == 3'd0, "R12 reset result", int'(result), 0);
    chk(in_ready == 1'b0, "R7 ready low at reset", int'(in_ready), 0);
    chk(target_in_reset == 1'b1, "R11 DONE low reports reset", int'(target_in_reset), 1);

    // R5: partial reconfiguration refused, pin untouched
    pulse_start(1'b1);
    chk(result == 3'd2, "R5 unsupported code", int'(result), 2);
    chk(prog_n && !busy, "R5 program pin untouched", int'({prog_n, busy}), 2);
    repeat (3) @(negedge clk);
    chk(prog_n && !busy, "R5 stays idle", int'({prog_n, busy}), 2);

    // R3 / R11: DONE high through the pulse
    force_done = 1'b1;
    repeat (3) @(negedge clk);
    chk(target_in_reset == 1'b0, "R11 DONE high reports configured", int'(target_in_reset), 0);
    base0 = byte_starts;
    pulse_start(1'b0);
    while (busy) @(negedge clk);
    chk(result == 3'd3, "R3 unexpected DONE code", int'(result), 3);
    chk(byte_starts == base0, "R3 no serial clocks", byte_starts - base0, 0);
    force_done = 1'b0;
    repeat (3) @(negedge clk);

    // directed cases
    run_load(1, 0, 1'b0);   // R8 DONE already high
    run_load(3, 2, 1'b0);   // R9 polling
    run_load(2, M, 1'b0);   // R9 at the limit
    run_load(2, 0, 1'b1);   // R10 timeout
    // random cases
    for (int r = 0; r < 8; r++)
      run_load($urandom_range(1, 5), $urandom_range(0, M), 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule